// File: doc/BRIEF.md
# Base and Limit Address Relocation Unit

This block turns a process-relative address into a physical address with two registers: a relocation base and a bounds limit. Each request is checked against the limit before any physical address is formed. A request that passes comes out one cycle later as base plus offset, with a valid flag. A request that fails comes out as a protection fault, and no address is issued for it.

The two registers are loaded through a write port that accepts writes only in privileged mode. A write made in user mode is dropped and raises an error pulse. Moving a process to a new location only needs a new base value. A build parameter sets how the limit is read: as the size of the process image, so the offset is compared, or as the last legal physical address, so the relocated sum is compared.

Top module: `reloc_unit`

## Requirements
- R1: While reset is held and after it is released, base and limit are zero and pa_valid_o, fault_o, pa_o and wr_err_o are all low.
- R2: With LIMIT_IS_END=0, a request is legal exactly when the zero-extended offset is strictly less than the limit.
- R3: A legal request gives pa_valid_o=1, fault_o=0 and pa_o = base + offset, truncated to PHYS_W bits.
- R4: An illegal request gives fault_o=1, pa_valid_o=0 and pa_o=0. The valid and fault outputs are never high together.
- R5: In a cycle without req_valid_i, the next cycle shows pa_valid_o=0, fault_o=0 and pa_o=0.
- R6: A write with priv_i=1 loads wr_data_i into the base when wr_sel_i=0, or into the limit when wr_sel_i=1. The new value applies from the next request cycle on.
- R7: A write with priv_i=0 changes neither register, and wr_err_o is high for exactly the following cycle.
- R8: When a write and a request fall in the same cycle, the request is translated and checked with the register values from before the write.
- R9: With LIMIT_IS_END=1, a request is legal exactly when base + offset has no carry out of PHYS_W bits and is no greater than the limit.
- R10: After only the base is rewritten, the same offsets translate to new base + offset, and legality is unchanged in size mode.
- R11: The result of a request appears on the outputs exactly one clock cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 base, 1 limit |
| wr_data_i | input | PHYS_W | Value to write |
| priv_i | input | 1 | Privileged mode of the writer |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | ADDR_W | Process-relative offset |
| pa_valid_o | output | 1 | Physical address is valid |
| pa_o | output | PHYS_W | Physical address |
| fault_o | output | 1 | Protection fault for the request |
| wr_err_o | output | 1 | A user-mode write was rejected |

## Verification
The hardest cases to reach are a relocated sum that carries out of the physical width in end-address mode, and a register write that lands in the same cycle as a request. Random stimulus seldom produces either. Directed steps place the base a few words below the top of the physical space and then issue offsets that cross it. Other steps put a base or limit write together with a request in one cycle. Two instances, one for each limit mode, share the same stimulus, so every boundary offset is judged under both rules at once.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
  parameter int PHYS_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [PHYS_W-1:0] wr_data_i,
  input  logic              priv_i,
  output logic [PHYS_W-1:0] base_o,
  output logic [PHYS_W-1:0] limit_o,
  output logic              wr_err_o
);
  import reloc_pkg::*;

  reg_sel_e sel;
  logic     wr_ok;

  assign sel   = reg_sel_e'(wr_sel_i);
  assign wr_ok = wr_en_i && priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      limit_o  <= '0;
      wr_err_o <= 1'b0;
    end else begin
      wr_err_o <= wr_en_i && !priv_i;
      if (wr_ok && sel == SEL_BASE)  base_o  <= wr_data_i;
      if (wr_ok && sel == SEL_LIMIT) limit_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/reloc_bounds.sv
module reloc_bounds #(
  parameter int ADDR_W       = 16,
  parameter int PHYS_W       = 20,
  parameter bit LIMIT_IS_END = 1'b0
) (
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [PHYS_W-1:0] base_i,
  input  logic [PHYS_W-1:0] limit_i,
  output logic [PHYS_W-1:0] sum_o,
  output logic              legal_o
);
  logic [PHYS_W-1:0] off_ext;

  assign off_ext = PHYS_W'(offset_i);
  assign sum_o   = base_i + off_ext;

  generate
    if (LIMIT_IS_END) begin : g_end
      logic [PHYS_W:0] wide;
      assign wide    = {1'b0, base_i} + {1'b0, off_ext};
      // carry out means the relocated address left the physical space
      assign legal_o = !wide[PHYS_W] && (wide[PHYS_W-1:0] <= limit_i);
    end else begin : g_size
      assign legal_o = off_ext < limit_i;
    end
  endgenerate
endmodule

// File: rtl/reloc_out_stage.sv
module reloc_out_stage #(
  parameter int PHYS_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              legal_i,
  input  logic [PHYS_W-1:0] sum_i,
  output logic              pa_valid_o,
  output logic [PHYS_W-1:0] pa_o,
  output logic              fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_valid_o <= 1'b0;
      pa_o       <= '0;
      fault_o    <= 1'b0;
    end else begin
      pa_valid_o <= req_valid_i && legal_i;
      fault_o    <= req_valid_i && !legal_i;
      pa_o       <= (req_valid_i && legal_i) ? sum_i : '0;
    end
  end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int ADDR_W       = 16,
  parameter int PHYS_W       = 20,
  parameter bit LIMIT_IS_END = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [PHYS_W-1:0] wr_data_i,
  input  logic              priv_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              pa_valid_o,
  output logic [PHYS_W-1:0] pa_o,
  output logic              fault_o,
  output logic              wr_err_o
);
  logic [PHYS_W-1:0] base_q;
  logic [PHYS_W-1:0] limit_q;
  logic [PHYS_W-1:0] sum;
  logic              legal;

  reloc_regs #(.PHYS_W(PHYS_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .priv_i    (priv_i),
    .base_o    (base_q),
    .limit_o   (limit_q),
    .wr_err_o  (wr_err_o)
  );

  // combinational check on current (pre-write) register values
  reloc_bounds #(
    .ADDR_W       (ADDR_W),
    .PHYS_W       (PHYS_W),
    .LIMIT_IS_END (LIMIT_IS_END)
  ) u_bounds (
    .offset_i (req_addr_i),
    .base_i   (base_q),
    .limit_i  (limit_q),
    .sum_o    (sum),
    .legal_o  (legal)
  );

  reloc_out_stage #(.PHYS_W(PHYS_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .legal_i     (legal),
    .sum_i       (sum),
    .pa_valid_o  (pa_valid_o),
    .pa_o        (pa_o),
    .fault_o     (fault_o)
  );
endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
  parameter int PHYS_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [PHYS_W-1:0] wr_data_i,
  input logic              priv_i,
  input logic              req_valid_i,
  input logic              pa_valid_o,
  input logic [PHYS_W-1:0] pa_o,
  input logic              fault_o,
  input logic              wr_err_o,
  input logic [PHYS_W-1:0] base_q,
  input logic [PHYS_W-1:0] limit_q
);
  // R4
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pa_valid_o && fault_o));

  // R4
  fault_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pa_o == '0);

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!pa_valid_o && !fault_o));

  // R11
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (pa_valid_o || fault_o));

  // R7
  user_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i) |=> wr_err_o);

  // R7
  user_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i) |=> ($stable(base_q) && $stable(limit_q)));

  // R6
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && priv_i && !wr_sel_i) |=> base_q == $past(wr_data_i));

  // R6
  limit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && priv_i && wr_sel_i) |=> limit_q == $past(wr_data_i));
endmodule

bind reloc_unit reloc_unit_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .priv_i      (priv_i),
  .req_valid_i (req_valid_i),
  .pa_valid_o  (pa_valid_o),
  .pa_o        (pa_o),
  .fault_o     (fault_o),
  .wr_err_o    (wr_err_o),
  .base_q      (base_q),
  .limit_q     (limit_q)
);

// File: tb/reloc_unit_tb.sv
module reloc_unit_tb_top;
  localparam int AW = 16;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_sel = 1'b0, priv = 1'b0, req_v = 1'b0;
  logic [PW-1:0] wr_data = '0;
  logic [AW-1:0] req_a = '0;

  logic          v_s, f_s, e_s, v_e, f_e, e_e;
  logic [PW-1:0] pa_s, pa_e;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  logic [PW-1:0] m_base = '0;
  logic [PW-1:0] m_limit = '0;

  always #2 clk = ~clk;

  reloc_unit #(.ADDR_W(AW), .PHYS_W(PW), .LIMIT_IS_END(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .priv_i(priv), .req_valid_i(req_v), .req_addr_i(req_a),
    .pa_valid_o(v_s), .pa_o(pa_s), .fault_o(f_s), .wr_err_o(e_s));

  reloc_unit #(.ADDR_W(AW), .PHYS_W(PW), .LIMIT_IS_END(1'b1)) dut_end_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .priv_i(priv), .req_valid_i(req_v), .req_addr_i(req_a),
    .pa_valid_o(v_e), .pa_o(pa_e), .fault_o(f_e), .wr_err_o(e_e));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit legal_of(bit end_mode, logic [AW-1:0] a);
    logic [PW:0] s;
    s = {1'b0, m_base} + {1'b0, PW'(a)};
    if (end_mode) return !s[PW] && (s[PW-1:0] <= m_limit);
    return PW'(a) < m_limit;
  endfunction

  function automatic logic [PW-1:0] sum_of(logic [AW-1:0] a);
    return m_base + PW'(a);
  endfunction

  // one cycle: drive at negedge, check after posedge, update model
  task automatic step(bit we, bit sel, logic [PW-1:0] d, bit pv, bit rv,
                      logic [AW-1:0] a, string tag);
    bit ls, le;
    logic [PW-1:0] s;
    string ts, te;
    wr_en = we; wr_sel = sel; wr_data = d; priv = pv; req_v = rv; req_a = a;
    ls = legal_of(1'b0, a);
    le = legal_of(1'b1, a);
    s  = sum_of(a);
    ts = (tag != "") ? tag : (!rv ? "R5" : (ls ? "R3" : "R4"));
    te = (tag != "") ? tag : (!rv ? "R5" : "R9");
    @(posedge clk); #1;
    chk(ts, "size valid", 32'(v_s), 32'(rv && ls));
    chk(ts, "size fault", 32'(f_s), 32'(rv && !ls));
    chk(ts, "size pa",    32'(pa_s), (rv && ls) ? 32'(s) : 32'd0);
    chk(te, "end valid",  32'(v_e), 32'(rv && le));
    chk(te, "end fault",  32'(f_e), 32'(rv && !le));
    chk(te, "end pa",     32'(pa_e), (rv && le) ? 32'(s) : 32'd0);
    chk("R7", "wr_err",   32'(e_s), 32'(we && !pv));
    chk("R7", "wr_err e", 32'(e_e), 32'(we && !pv));
    if (we && pv) begin
      if (sel) m_limit = d; else m_base = d;
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 outputs while in reset
    chk("R1", "valid in reset", 32'(v_s | v_e), 0);
    chk("R1", "fault in reset", 32'(f_s | f_e), 0);
    chk("R1", "pa in reset", 32'(pa_s | pa_e), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "err after reset", 32'(e_s | e_e), 0);
    // R1: zero limit -> size mode faults, end mode admits offset 0 at base 0
    step(0, 0, '0, 0, 1, 16'd0, "R1");
    step(0, 0, '0, 0, 0, 16'd0, "R5");

    // R6 load base and limit
    step(1, 0, 20'h00400, 1, 0, 16'd0, "R6");
    step(1, 1, 20'd100, 1, 0, 16'd0, "R6");
    // R2 strict boundary in size mode, R11 one-cycle result
    step(0, 0, '0, 0, 1, 16'd99, "R2");
    step(0, 0, '0, 0, 1, 16'd100, "R2");
    step(0, 0, '0, 0, 1, 16'd0, "R11");
    // R9 end-address boundary: limit = base + 99
    step(1, 1, 20'h00400 + 20'd99, 1, 0, 16'd0, "R6");
    step(0, 0, '0, 0, 1, 16'd99, "R9");
    step(0, 0, '0, 0, 1, 16'd100, "R9");
    // R7 user-mode write ignored; following request shows old base
    step(1, 0, 20'h12345, 0, 0, 16'd0, "R7");
    step(0, 0, '0, 0, 1, 16'd5, "R7");
    step(1, 1, 20'd1, 0, 1, 16'd6, "R7");
    // R8 same-cycle write and request uses old values
    step(1, 0, 20'h08000, 1, 1, 16'd7, "R8");
    step(0, 0, '0, 0, 1, 16'd7, "R10");
    step(1, 1, 20'd3, 1, 1, 16'd50, "R8");
    // R10 relocation: only base changes
    step(1, 1, 20'hFFFFF, 1, 0, 16'd0, "R6");
    step(1, 0, 20'h01000, 1, 0, 16'd0, "R10");
    step(0, 0, '0, 0, 1, 16'd300, "R10");
    step(1, 0, 20'h22000, 1, 0, 16'd0, "R10");
    step(0, 0, '0, 0, 1, 16'd300, "R10");
    // R9 carry out of physical width
    step(1, 0, 20'hFFFF0, 1, 0, 16'd0, "R6");
    step(0, 0, '0, 0, 1, 16'h000F, "R9");
    step(0, 0, '0, 0, 1, 16'h0010, "R9");
    step(0, 0, '0, 0, 1, 16'h0020, "R9");

    for (int i = 0; i < 600; i++) begin
      int k;
      logic [PW-1:0] d;
      k = $urandom_range(0, 9);
      if (k == 0)      d = 20'hFFFFF - PW'($urandom_range(0, 300));
      else if (k < 5)  d = PW'($urandom_range(0, 1024));
      else             d = PW'($urandom_range(0, 2048));
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, d,
           $urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0,
           AW'($urandom_range(0, 1200)), "");
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule